// File: doc/BRIEF.md
# Binary Arithmetic Encoder Renormalization Unit

This block performs the renormalization step of a binary arithmetic encoder in a single clock. Upstream logic narrows the coding interval for each symbol and presents the new lower and upper bounds. The unit finds how many leading bits the two bounds agree on, and how many straddle (underflow) positions follow the first disagreeing bit. It then returns the code bits that are now decided, left-aligned with a valid count, together with the rescaled bounds for the next symbol.

The loop that a software encoder runs one bit at a time is unrolled here. A leading-zero count of `low_in ^ high_in` gives the shared-prefix length. Straddle runs are measured for every possible prefix length at once, and the prefix length selects one of them. A register keeps the number of deferred straddle bits between symbols. Those bits are released as complements of the next decided bit. A flush command ends a stream by emitting enough bits to land inside the final interval. It then returns the unit to its initial interval.

Top module: `ac_renorm_unit`

## Requirements
- R1: After reset `out_valid` is 0, `out_count` is 0, `out_bits` is 0, `pend_count` is 0, `low_out` is all zeros and `high_out` is all ones.
- R2: For an accepted symbol (`in_valid`=1, `flush`=0, with `low_in` <= `high_in`), the number c of leading bit positions where `low_in` and `high_in` agree is shifted out of both bounds. Zeros enter `low_out` from the right and ones enter `high_out`. Afterwards `low_out` has MSB 0 and `high_out` has MSB 1.
- R3: When c > 0 the output is emitted MSB first from bit OUT_W-1 of `out_bits`. The order is: the first shared bit, then P copies of its complement (P being the pending count before the symbol), then the remaining c-1 shared bits. `out_count` is c+P and every bit of `out_bits` past the count is 0.
- R4: After the shared prefix, the straddle count u is the number of consecutive positions, starting just below the first disagreeing bit, where `low_in` holds 1 and `high_in` holds 0. Those u positions are removed from both bounds with each bound's MSB kept, and fills enter as in R2. If c > 0, `pend_count` becomes u.
- R5: When c = 0, `out_count` is 0 (`out_valid` still pulses) and `pend_count` grows by u.
- R6: `pend_count` holds any value up to 2^PEND_W-1 without wrapping; the caller keeps it within that range.
- R7: `flush` takes priority over `in_valid`. It emits b = 1 when `low_out` >= one quarter of the range (else 0), followed by P+1 copies of not b, giving `out_count` P+2. It then sets `pend_count` to 0, `low_out` to all zeros and `high_out` to all ones.
- R8: A cycle with neither `in_valid` nor `flush` leaves `out_valid` and `out_count` at 0 in the next cycle and keeps `low_out`, `high_out` and `pend_count` unchanged.
- R9: All results are registered. They appear in the cycle after the accepting edge, and `out_valid` is high for exactly one cycle per accepted symbol or flush.
- R10: Equal bounds give c = W: all W bits of `low_in` are emitted after any pending bits, and the bounds return to all zeros and all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New bound pair presented |
| flush | input | 1 | End-of-stream command |
| low_in | input | W | Updated lower bound |
| high_in | input | W | Updated upper bound |
| out_valid | output | 1 | Result registered this cycle |
| out_bits | output | OUT_W | Code bits, MSB first from the top bit |
| out_count | output | CNT_W | Number of valid bits in `out_bits` |
| low_out | output | W | Rescaled lower bound |
| high_out | output | W | Rescaled upper bound |
| pend_count | output | PEND_W | Deferred straddle bits |

## Verification
Bound pairs with a random shared prefix of every length check the prefix count and the fill directions. Pairs built as 01x…/10y… give no shared prefix and straddle runs of varied length, which separates the no-output accumulation path from the emitting path. A long run of single-straddle symbols drives the pending count to its maximum, and the next emitting symbol then shows that the deferred complements are placed between the first and second shared bits. Equal bounds, a flush raised together with `in_valid`, and idle gaps cover the remaining corners. A bit-serial loop in the bench predicts every output each cycle.

// File: rtl/ac_renorm_pkg.sv
package ac_renorm_pkg;

   // Width of the left-aligned output vector: a full bound plus the largest
   // pending run that the pending register can hold.
   function automatic int out_width(input int w, input int pend_w);
      return w + (1 << pend_w) - 1;
   endfunction

   // Width of a count that can reach n.
   function automatic int cnt_width(input int n);
      return $clog2(n + 1);
   endfunction

endpackage

// File: rtl/ac_lzd.sv
module ac_lzd #(
   parameter int W  = 16,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] zeros
);

   generate
      if (W < 2) begin : g_bad_width
         $error("ac_lzd: W must be at least 2");
      end
   endgenerate

   always_comb begin
      logic found;
      found = 1'b0;
      zeros = CW'(W);
      for (int i = W - 1; i >= 0; i--) begin
         if (!found && vec[i]) begin
            zeros = CW'(W - 1 - i);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ac_straddle_scan.sv
module ac_straddle_scan #(
   parameter int W  = 16,
   localparam int CW    = $clog2(W + 1),
   localparam int NCAND = W - 1
) (
   input  logic [W-1:0]  low_in,
   input  logic [W-1:0]  high_in,
   input  logic [CW-1:0] prefix_len,
   output logic [CW-1:0] straddle_len
);

   // gate stage: a straddle position has low=1, high=0
   logic [W-1:0]  straddle_map;
   logic [CW-1:0] cand [NCAND];

   assign straddle_map = low_in & ~high_in;

   // one candidate per possible prefix length k; the bits below the first
   // differing position (W-1-k) are left-aligned and their leading ones counted
   generate
      for (genvar k = 0; k < NCAND; k++) begin : g_cand
         logic [W-1:0] aligned;
         assign aligned = ~(straddle_map << (k + 1));
         ac_lzd #(.W(W)) i_lzd (
            .vec   (aligned),
            .zeros (cand[k])
         );
      end
   endgenerate

   always_comb begin
      straddle_len = '0;
      for (int k = 0; k < NCAND; k++) begin
         if (prefix_len == CW'(k)) begin
            straddle_len = cand[k];
         end
      end
   end

endmodule

// File: rtl/ac_bit_pack.sv
module ac_bit_pack #(
   parameter int W      = 16,
   parameter int PEND_W = 5,
   localparam int OUT_W  = ac_renorm_pkg::out_width(W, PEND_W),
   localparam int CNT_W  = ac_renorm_pkg::cnt_width(OUT_W),
   localparam int FW     = PEND_W + 1,
   localparam int PAD_W  = OUT_W - W
) (
   input  logic             lead_bit,
   input  logic [W-2:0]     body,
   input  logic [FW-1:0]    follow_len,
   input  logic [CNT_W-1:0] total,
   output logic [OUT_W-1:0] vec
);

   logic [OUT_W-2:0] tail_aligned;
   logic [OUT_W-2:0] tail_shifted;
   logic [OUT_W-2:0] follow_mask;
   logic [OUT_W-2:0] tail;
   logic [OUT_W-1:0] keep_mask;

   assign tail_aligned = {body, {PAD_W{1'b0}}};
   assign tail_shifted = tail_aligned >> follow_len;
   assign follow_mask  = ~({(OUT_W-1){1'b1}} >> follow_len);
   assign tail         = (tail_shifted & ~follow_mask) |
                         (lead_bit ? '0 : follow_mask);
   assign keep_mask    = ~({OUT_W{1'b1}} >> total);
   assign vec          = {lead_bit, tail} & keep_mask;

endmodule

// File: rtl/ac_renorm_unit.sv
module ac_renorm_unit #(
   parameter int W      = 16,
   parameter int PEND_W = 5,
   localparam int OUT_W = ac_renorm_pkg::out_width(W, PEND_W),
   localparam int CNT_W = ac_renorm_pkg::cnt_width(OUT_W),
   localparam int CW    = $clog2(W + 1),
   localparam int FW    = PEND_W + 1,
   localparam int SUM_W = CW + PEND_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             flush,
   input  logic [W-1:0]     low_in,
   input  logic [W-1:0]     high_in,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_bits,
   output logic [CNT_W-1:0] out_count,
   output logic [W-1:0]     low_out,
   output logic [W-1:0]     high_out,
   output logic [PEND_W-1:0] pend_count
);

   generate
      if (W < 4) begin : g_bad_w
         $error("ac_renorm_unit: W must be at least 4");
      end
      if (PEND_W < 1 || PEND_W > 12) begin : g_bad_pend
         $error("ac_renorm_unit: PEND_W must be in 1..12");
      end
   endgenerate

   // ---------------- state ----------------
   logic [W-1:0]      low_q, high_q;
   logic [PEND_W-1:0] pend_q;
   logic              vld_q;
   logic [OUT_W-1:0]  bits_q;
   logic [CNT_W-1:0]  cnt_q;

   // ---------------- prefix and straddle ----------------
   logic [CW-1:0] prefix_len;
   logic [CW-1:0] straddle_len;

   ac_lzd #(.W(W)) i_prefix (
      .vec   (low_in ^ high_in),
      .zeros (prefix_len)
   );

   ac_straddle_scan #(.W(W)) i_scan (
      .low_in       (low_in),
      .high_in      (high_in),
      .prefix_len   (prefix_len),
      .straddle_len (straddle_len)
   );

   // ---------------- bound rescaling ----------------
   logic [W-1:0] low_pfx, high_pfx;
   logic [W-1:0] low_nxt, high_nxt;

   assign low_pfx  = low_in << prefix_len;
   assign high_pfx = ~((~high_in) << prefix_len);
   assign low_nxt  = {low_pfx[W-1],  low_pfx[W-2:0] << straddle_len};
   assign high_nxt = {high_pfx[W-1], ~((~high_pfx[W-2:0]) << straddle_len)};

   // ---------------- pending update ----------------
   logic              has_prefix;
   logic [SUM_W-1:0]  pend_sum;
   logic [PEND_W-1:0] pend_nxt;

   assign has_prefix = (prefix_len != '0);
   assign pend_sum   = SUM_W'(pend_q) + SUM_W'(straddle_len);
   assign pend_nxt   = has_prefix ? PEND_W'(straddle_len) : pend_sum[PEND_W-1:0];

   // ---------------- emission select ----------------
   logic             pk_lead;
   logic [W-2:0]     pk_body;
   logic [FW-1:0]    pk_follow;
   logic [CNT_W-1:0] pk_total;
   logic [OUT_W-1:0] pk_vec;

   always_comb begin
      if (flush) begin
         pk_lead   = |low_q[W-1:W-2];
         pk_body   = '0;
         pk_follow = FW'(pend_q) + FW'(1);
         pk_total  = CNT_W'(pend_q) + CNT_W'(2);
      end else begin
         pk_lead   = low_in[W-1];
         pk_body   = low_in[W-2:0];
         pk_follow = FW'(pend_q);
         pk_total  = has_prefix ? (CNT_W'(prefix_len) + CNT_W'(pend_q)) : '0;
      end
   end

   ac_bit_pack #(.W(W), .PEND_W(PEND_W)) i_pack (
      .lead_bit   (pk_lead),
      .body       (pk_body),
      .follow_len (pk_follow),
      .total      (pk_total),
      .vec        (pk_vec)
   );

   // ---------------- registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         high_q <= '1;
         pend_q <= '0;
         vld_q  <= 1'b0;
         bits_q <= '0;
         cnt_q  <= '0;
      end else begin
         vld_q  <= flush | in_valid;
         bits_q <= (flush | in_valid) ? pk_vec : '0;
         cnt_q  <= (flush | in_valid) ? pk_total : '0;
         if (flush) begin
            low_q  <= '0;
            high_q <= '1;
            pend_q <= '0;
         end else if (in_valid) begin
            low_q  <= low_nxt;
            high_q <= high_nxt;
            pend_q <= pend_nxt;
         end
      end
   end

   assign out_valid  = vld_q;
   assign out_bits   = bits_q;
   assign out_count  = cnt_q;
   assign low_out    = low_q;
   assign high_out   = high_q;
   assign pend_count = pend_q;

endmodule

// File: rtl/ac_renorm_checker.sv
module ac_renorm_checker #(
   parameter int W      = 16,
   parameter int PEND_W = 5,
   localparam int OUT_W = ac_renorm_pkg::out_width(W, PEND_W),
   localparam int CNT_W = ac_renorm_pkg::cnt_width(OUT_W)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             flush,
   input logic [W-1:0]     low_in,
   input logic [W-1:0]     high_in,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_bits,
   input logic [CNT_W-1:0] out_count,
   input logic [W-1:0]     low_out,
   input logic [W-1:0]     high_out,
   input logic [PEND_W-1:0] pend_count
);

   // R2: rescaled bounds always straddle the midpoint
   p_bounds_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !low_out[W-1] && high_out[W-1]);

   // R3: a symbol with a shared MSB emits more bits than were pending
   p_emit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !flush && (low_in[W-1] == high_in[W-1]))
      |=> (int'(out_count) > int'($past(pend_count))));

   // R3: nothing beyond the count is set
   p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_count == '0) |-> (out_bits == '0));

   // R5: no shared prefix means no output bits
   p_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !flush && (low_in[W-1] != high_in[W-1]))
      |=> (out_valid && out_count == '0));

   // R6: the pending count only grows on a no-prefix symbol
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !flush && (low_in[W-1] != high_in[W-1]))
      |=> (pend_count >= $past(pend_count)));

   // R7: flush emits pending+2 bits and restores the initial interval
   p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (out_valid && int'(out_count) == int'($past(pend_count)) + 2 &&
                 pend_count == '0 && low_out == '0 && (&high_out)));

   // R8: idle cycles hold state and emit nothing
   p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !flush) |=> (!out_valid && out_count == '0 &&
         $stable(low_out) && $stable(high_out) && $stable(pend_count)));

   // R9: every accepted operation yields a result one cycle later
   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid || flush) |=> out_valid);

endmodule

bind ac_renorm_unit ac_renorm_checker #(.W(W), .PEND_W(PEND_W)) i_ac_renorm_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .flush      (flush),
   .low_in     (low_in),
   .high_in    (high_in),
   .out_valid  (out_valid),
   .out_bits   (out_bits),
   .out_count  (out_count),
   .low_out    (low_out),
   .high_out   (high_out),
   .pend_count (pend_count)
);

// File: tb/test_ac_renorm_unit.sv
`timescale 1ns/1ps
module test_ac_renorm_unit;

   localparam int W      = 16;
   localparam int PEND_W = 5;
   localparam int OUT_W  = W + (1 << PEND_W) - 1;
   localparam int CNT_W  = $clog2(OUT_W + 1);
   localparam int TOP    = 65536;
   localparam int HALF   = 32768;
   localparam int QTR    = 16384;
   localparam int MAXP   = (1 << PEND_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              flush = 1'b0;
   logic [W-1:0]      low_in = '0;
   logic [W-1:0]      high_in = '0;
   logic              out_valid;
   logic [OUT_W-1:0]  out_bits;
   logic [CNT_W-1:0]  out_count;
   logic [W-1:0]      low_out;
   logic [W-1:0]      high_out;
   logic [PEND_W-1:0] pend_count;

   always #2.5 clk = ~clk;

   ac_renorm_unit #(.W(W), .PEND_W(PEND_W)) i_ac_renorm_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flush(flush),
      .low_in(low_in), .high_in(high_in), .out_valid(out_valid),
      .out_bits(out_bits), .out_count(out_count), .low_out(low_out),
      .high_out(high_out), .pend_count(pend_count));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // ---------------- bit-serial reference ----------------
   int m_low = 0, m_high = TOP - 1, m_pend = 0;
   bit q[$];
   int e_valid;

   function automatic void m_emit(bit b);
      q.push_back(b);
      for (int i = 0; i < m_pend; i++) q.push_back(!b);
      m_pend = 0;
   endfunction

   function automatic void m_code(int lo, int hi);
      int l = lo;
      int h = hi;
      while (1) begin
         if (h < HALF) begin
            m_emit(1'b0);
         end else if (l >= HALF) begin
            m_emit(1'b1);
            l -= HALF; h -= HALF;
         end else if (l >= QTR && h < HALF + QTR) begin
            m_pend++;
            l -= QTR; h -= QTR;
         end else begin
            break;
         end
         l = 2 * l;
         h = 2 * h + 1;
      end
      m_low = l;
      m_high = h;
   endfunction

   function automatic void m_flush();
      bit b = (m_low >= QTR);
      m_pend++;
      m_emit(b);
      m_low = 0; m_high = TOP - 1; m_pend = 0;
   endfunction

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      logic [OUT_W-1:0] eb = '0;
      for (int i = 0; i < q.size(); i++) eb[OUT_W-1-i] = q[i];
      chk(tag, "out_valid", longint'(out_valid), longint'(e_valid));
      chk(tag, "out_count", longint'(out_count), longint'(q.size()));
      chk(tag, "out_bits", longint'(out_bits), longint'(eb));
      chk(tag, "low_out", longint'(low_out), longint'(m_low));
      chk(tag, "high_out", longint'(high_out), longint'(m_high));
      chk(tag, "pend_count", longint'(pend_count), longint'(m_pend));
   endtask

   // drive one operation at a falling edge, check one cycle later
   task automatic step(bit v, bit f, int lo, int hi, string tag);
      in_valid = v; flush = f;
      low_in = W'(lo); high_in = W'(hi);
      q.delete();
      e_valid = v | f;
      if (f) m_flush();
      else if (v) m_code(lo, hi);
      @(negedge clk);
      compare(tag);
   endtask

   // random symbol that keeps the pending count in range
   task automatic rand_step(bit straddle);
      int lo, hi, sl, sh, sp;
      if (straddle) begin
         lo = QTR + int'($urandom_range(0, QTR - 1));
         hi = HALF + int'($urandom_range(0, QTR - 1));
      end else begin
         int k = int'($urandom_range(0, W));
         lo = int'($urandom_range(0, TOP - 1));
         hi = lo | ((1 << k) - 1);
         if (hi > TOP - 1) hi = TOP - 1;
      end
      sl = m_low; sh = m_high; sp = m_pend;
      q.delete();
      m_code(lo, hi);
      m_low = sl; m_high = sh; m_pend = sp;
      // the trial above changed only a copy; a pending overflow is avoided
      // by falling back to equal bounds, which release every pending bit
      begin
         int tl = lo, th = hi, tp = sp, p2;
         p2 = tp;
         q.delete();
         m_pend = sp; m_code(tl, th); p2 = m_pend;
         m_low = sl; m_high = sh; m_pend = sp;
         if (p2 > MAXP) begin lo = hi; end
      end
      step(1'b1, 1'b0, lo, hi, straddle ? "R4" : "R2");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      q.delete(); e_valid = 0;
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R10: equal bounds
      step(1'b1, 1'b0, 'hA5C3, 'hA5C3, "R10");
      // R4: straddle run of two, no prefix
      step(1'b1, 1'b0, 'h6F00, 'h9080, "R4");
      // R5: accumulate single straddles
      for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 'h4000, 'hBFFF, "R5");
      // R6: fill to the maximum pending count
      while (m_pend < MAXP) step(1'b1, 1'b0, 'h4000, 'hBFFF, "R6");
      // R3: emit with full pending run
      step(1'b1, 1'b0, 'h2000, 'h3FFF, "R3");
      // R8: idle
      step(1'b0, 1'b0, 'h1234, 'h0001, "R8");
      step(1'b0, 1'b0, 'h0000, 'hFFFF, "R8");
      // R3: prefix of one with pending bits
      step(1'b1, 1'b0, 'h5000, 'hA800, "R5");
      step(1'b1, 1'b0, 'h8123, 'hC000, "R3");
      // R7: flush with in_valid also high
      step(1'b1, 1'b1, 'h0000, 'h0000, "R7");
      // R9: back-to-back symbols after flush
      step(1'b1, 1'b0, 'h1111, 'h1FFF, "R9");
      step(1'b1, 1'b0, 'h3000, 'hC000, "R9");
      // random mix
      for (int i = 0; i < 400; i++) rand_step(($urandom % 3) == 0);
      step(1'b0, 1'b1, 0, 0, "R7");
      step(1'b0, 1'b0, 0, 0, "R8");
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule